// File: doc/BRIEF.md
# Watchdog Timer with Assignable Prescaler

This block is a watchdog that counts ticks from its own free-running time base. That time base is separate from the core clock, so the watchdog keeps counting while the core is stopped in sleep. The time-out period is a base period, given in ticks. Software can stretch this period with a prescaler that divides by a power of two from 1 up to 128. When the prescaler is not assigned to the watchdog, every tick advances the watchdog counter directly.

Software stops a pending time-out with a clear command. The sleep command also restarts the whole chain, so the core gets the full period of sleep before it is woken. When the period elapses, the block raises a one-cycle reset request. If the core is asleep at that moment, a wake event comes with the request. The block also drops a status flag, which a later clear, a sleep command or power-on sets again. A configuration enable held low silences the watchdog completely.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset, `wdt_reset_req` and `wdt_wake` are 0 and `wdt_ok` is 1.
- R2: With `pre_assign`=0 and the watchdog enabled, `wdt_reset_req` pulses on the BASE_PERIOD-th tick after the last restart, and on no earlier tick.
- R3: With `pre_assign`=1, the field `pre_sel`=n selects a division ratio of 2^n. `wdt_reset_req` then pulses on the (BASE_PERIOD x 2^n)-th tick after the last restart.
- R4: A `clr_cmd` cycle restarts both the prescaler and the watchdog counter, and sets `wdt_ok` to 1. A tick in that same cycle is ignored, so a clear on the final tick prevents the time-out.
- R5: A `sleep_cmd` cycle has the same restart effect as `clr_cmd`, including priority over a coinciding tick.
- R6: The counter keeps advancing while `core_asleep`=1. `wdt_wake` pulses in the same cycle as `wdt_reset_req` if and only if `core_asleep` was 1 on the expiring tick.
- R7: `wdt_reset_req` is high for exactly one cycle. The count then restarts from zero, and the next time-out comes one full period later.
- R8: A time-out clears `wdt_ok` to 0. It stays 0 until a clear, a sleep command or a reset.
- R9: While `cfg_wdt_en`=0, no tick produces a time-out, and the count stays at zero.
- R10: Cycles with `wdt_tick`=0 do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog time-base clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_tick | input | 1 | Tick enable, one count step per high cycle |
| cfg_wdt_en | input | 1 | Configuration enable (0 = watchdog off) |
| pre_assign | input | 1 | 1 = prescaler divides watchdog ticks |
| pre_sel | input | SEL_W | Ratio exponent n, ratio 2^n |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Sleep command strobe |
| core_asleep | input | 1 | Core is currently in sleep |
| wdt_reset_req | output | 1 | One-cycle device reset request on time-out |
| wdt_wake | output | 1 | Wake-from-sleep event, coincides with reset request |
| wdt_ok | output | 1 | Time-out status flag, 0 after a watchdog time-out |

## Verification
Two functions can land in the same cycle: a restart from a clear or sleep command, and the tick that would make the period expire. The bench lines the count up so that the command arrives exactly on the final tick of a period, and it does this for the clear and for the sleep strobe. It then expects no pulse, `wdt_ok` high, and a time-out one full period later. Random segments also let the strobes fall on arbitrary ticks, and every cycle is compared against a tick-count model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef struct packed {
        logic reset_req;
        logic wake;
        logic ok;
    } wdt_out_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W = 3,
    localparam int PRE_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic             assigned,
    input  logic [SEL_W-1:0] sel,
    output logic             advance
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        st_d    = st_q;
        advance = 1'b0;
        if (!en || restart) begin
            st_d.cnt = '0;
        end else if (!assigned) begin
            st_d.cnt = '0;
            advance  = tick;
        end else if (tick) begin
            if (st_q.cnt >= mask) begin
                st_d.cnt = '0;
                advance  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4 / R5: a restart command leaves the prescaler at zero
    assert_pre_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.cnt == '0);

    // R9: a disabled watchdog keeps its prescaler empty
    assert_pre_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st_q.cnt == '0);

endmodule

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
    parameter int BASE_PERIOD = 18,
    localparam int CNT_W = $clog2(BASE_PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic advance,
    output logic expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!en || restart) begin
            st_d.cnt = '0;
        end else if (advance) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the count never reaches the period itself
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(BASE_PERIOD));

    // R5: restart (clear or sleep) zeroes the watchdog count
    assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.cnt == '0);

    // R10: no advance, no change in the count
    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && !advance) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int BASE_PERIOD = 18,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_tick,
    input  logic             cfg_wdt_en,
    input  logic             pre_assign,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic             clr_cmd,
    input  logic             sleep_cmd,
    input  logic             core_asleep,
    output logic             wdt_reset_req,
    output logic             wdt_wake,
    output logic             wdt_ok
);
    import wdt_pkg::*;

    initial begin
        if (BASE_PERIOD < 2) $error("BASE_PERIOD must be at least 2");
    end

    logic     restart;
    logic     advance;
    logic     expire;
    wdt_out_t out_d, out_q;

    assign restart = clr_cmd | sleep_cmd;

    wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_wdt_en),
        .tick     (wdt_tick),
        .restart  (restart),
        .assigned (pre_assign),
        .sel      (pre_sel),
        .advance  (advance)
    );

    wdt_base_counter #(.BASE_PERIOD(BASE_PERIOD)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_wdt_en),
        .restart (restart),
        .advance (advance),
        .expire  (expire)
    );

    always_comb begin
        out_d           = out_q;
        out_d.reset_req = expire;
        out_d.wake      = expire & core_asleep;
        if (restart)     out_d.ok = 1'b1;
        else if (expire) out_d.ok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{reset_req: 1'b0, wake: 1'b0, ok: 1'b1};
        else        out_q <= out_d;
    end

    assign wdt_reset_req = out_q.reset_req;
    assign wdt_wake      = out_q.wake;
    assign wdt_ok        = out_q.ok;

    // R7: a time-out request lasts a single cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |=> !wdt_reset_req);

    // R6: a wake event only comes with a reset request
    assert_wake_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_wake |-> wdt_reset_req);

    // R8: a time-out leaves the status flag low
    assert_status_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> !wdt_ok);

    // R4: clear or sleep sets the status flag and suppresses a time-out
    assert_restart_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (wdt_ok && !wdt_reset_req));

    // R9: no time-out follows a disabled cycle
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wdt_en |=> !wdt_reset_req);

endmodule

// File: tb/wdt_top_test.sv
module wdt_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wdt_tick = 1'b0;
    logic          cfg_wdt_en = 1'b1;
    logic          pre_assign = 1'b0;
    logic [SW-1:0] pre_sel = '0;
    logic          clr_cmd = 1'b0;
    logic          sleep_cmd = 1'b0;
    logic          core_asleep = 1'b0;
    logic          wdt_reset_req, wdt_wake, wdt_ok;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    int  m_cnt = 0;
    bit  m_ok = 1'b1;
    bit  e_req, e_wake;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_top #(.BASE_PERIOD(BASE), .SEL_W(SW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_tick      (wdt_tick),
        .cfg_wdt_en    (cfg_wdt_en),
        .pre_assign    (pre_assign),
        .pre_sel       (pre_sel),
        .clr_cmd       (clr_cmd),
        .sleep_cmd     (sleep_cmd),
        .core_asleep   (core_asleep),
        .wdt_reset_req (wdt_reset_req),
        .wdt_wake      (wdt_wake),
        .wdt_ok        (wdt_ok)
    );

    function automatic int period_ticks(bit assigned, logic [SW-1:0] sel);
        return assigned ? (BASE << sel) : BASE;
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, update the model for the
    // rising edge, compare at the next falling edge.
    task automatic step(string tag, bit tk, bit clr, bit slp);
        wdt_tick  = tk;
        clr_cmd   = clr;
        sleep_cmd = slp;
        e_req  = 1'b0;
        e_wake = 1'b0;
        if (!cfg_wdt_en) begin
            m_cnt = 0;
            if (clr || slp) m_ok = 1'b1;
        end else if (clr || slp) begin
            m_cnt = 0;
            m_ok  = 1'b1;
        end else if (tk) begin
            m_cnt++;
            if (m_cnt >= period_ticks(pre_assign, pre_sel)) begin
                m_cnt  = 0;
                e_req  = 1'b1;
                e_wake = core_asleep;
                m_ok   = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "reset_req", wdt_reset_req, e_req);
        check(tag, "wake", wdt_wake, e_wake);
        check(tag, "ok", wdt_ok, m_ok);
    endtask

    task automatic run_ticks(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "reset_req", wdt_reset_req, 1'b0);
        check("R1", "wake", wdt_wake, 1'b0);
        check("R1", "ok", wdt_ok, 1'b1);
        rst_n = 1'b1;

        // R2: raw ticks, time-out on the BASE-th tick, with R7 repeat
        run_ticks("R2", BASE);
        run_ticks("R7", BASE * 2);

        // R8: status stays low across idle cycles
        for (int i = 0; i < 4; i++) step("R8", 1'b0, 1'b0, 1'b0);

        // R10: ticks with gaps
        step("R4", 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < BASE * 3; i++) step("R10", i[0], 1'b0, 1'b0);

        // R3: prescaler ratios 2^n for several n
        for (int n = 0; n < 8; n += 3) begin
            pre_assign = 1'b1;
            pre_sel    = SW'(n);
            step("R3", 1'b1, 1'b1, 1'b0);
            run_ticks("R3", (BASE << n) + 2);
        end
        pre_sel = 3'd7;
        step("R3", 1'b0, 1'b1, 1'b0);
        run_ticks("R3", BASE * 128 + 1);

        // R4: clear on the expiring tick
        pre_assign = 1'b0;
        step("R4", 1'b0, 1'b1, 1'b0);
        run_ticks("R4", BASE - 1);
        step("R4", 1'b1, 1'b1, 1'b0);
        run_ticks("R4", BASE);

        // R5: sleep on the expiring tick, with prescaler 1:4
        pre_assign = 1'b1;
        pre_sel    = 3'd2;
        step("R5", 1'b0, 1'b0, 1'b1);
        run_ticks("R5", BASE * 4 - 1);
        step("R5", 1'b1, 1'b0, 1'b1);
        run_ticks("R5", 3);

        // R6: keeps counting while asleep, wake comes with the request
        core_asleep = 1'b1;
        run_ticks("R6", BASE * 4 * 2);
        core_asleep = 1'b0;
        run_ticks("R6", BASE * 4);

        // R9: disabled watchdog never times out
        cfg_wdt_en = 1'b0;
        run_ticks("R9", BASE * 40);
        cfg_wdt_en = 1'b1;
        step("R9", 1'b0, 1'b1, 1'b0);

        // Random segments, configuration changed together with a clear
        for (int s = 0; s < 40; s++) begin
            cfg_wdt_en = ($urandom_range(9) != 0);
            pre_assign = $urandom_range(1);
            pre_sel    = SW'($urandom_range(4));
            step("R2", 1'b0, 1'b1, 1'b0);
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(49) == 0) core_asleep = ~core_asleep;
                step("R2", ($urandom_range(4) != 0),
                     ($urandom_range(199) == 0), ($urandom_range(199) == 0));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule